// File: doc/BRIEF.md
# Video Memory Block-Write Engine

This block is a clock-synchronous model of the write side of a dual-port video memory. It watches the asynchronous memory strobes: a row strobe, two byte-lane column strobes, write enable, a transfer gate and a special-function select. It also watches a 9-bit multiplexed address and a 16-bit data bus. Each strobe passes through a two-flop synchronizer. Edges are found in the system clock domain. On every fall of the row strobe the engine decides what kind of cycle is starting and keeps that decision until the row strobe rises again.

The engine keeps a persistent per-bit write mask and a color value. A block write copies the color into a group of adjacent columns in one memory cycle. Each column of the group is enabled by a column-mask bit, and each bit of a written word is enabled by the persistent mask. A normal write stores one whole data word at one column. A refresh cycle leaves the storage untouched. The storage is a small on-chip array, and a registered read port exposes it. The usual sequence is: load the bit mask once, load the color, then issue any number of block writes.

Top module: `vram_blkwr_engine`

## Requirements
- R1: After reset, every stored word reads 0, `cyc_type` is 0 (idle), the color is 0 and the bit mask is all ones. A block write issued before any mask load therefore writes every bit of the color.
- R2: At each row-strobe fall, the levels of `trg_n`, `we_n` and `dsf` select the cycle type shown on `cyc_type`. The encoding is: `trg_n`=0 gives refresh (1); {`we_n`,`dsf`}=10 gives normal write (2); 00 gives load mask (3); 11 gives load color (4); 01 gives block write (5). The value is held while the row strobe stays low and returns to 0 after it rises.
- R3: In a load-mask cycle, the value on `dq` at the row-strobe fall becomes the bit mask. It stays in force for every later block write until the next load-mask cycle.
- R4: Within a cycle, the data word is taken from `dq` at whichever comes first: the write-enable fall or the first column-strobe fall. Later edges in the same cycle do not replace it. A load-color cycle stores that word as the color when the row strobe rises.
- R5: The column strobe is active while either byte strobe, or both, is low. Only the first fall of this combined strobe in a cycle captures the column address.
- R6: A stored word is addressed by `addr[1:0]` (taken at the row-strobe fall) for the row and by `addr[4:0]` (taken at the first column-strobe fall) for the column. Higher address bits are ignored. A block write covers the aligned group of 2^BLK_LOG columns that contains the captured column.
- R7: When the row strobe rises at the end of a block-write cycle, column i of the group is written only if bit i of the captured data word (the column mask) is 1. In each written column, only bits whose mask bit is 1 take the color; all other bits and columns keep their values.
- R8: When the row strobe rises at the end of a normal-write cycle, the captured data word is written whole at the captured column. This happens only if a column-strobe fall occurred and write enable was low at some point during the cycle.
- R9: A refresh cycle changes no stored word, whatever the column, write-enable and data activity during it.
- R10: The parameter BLK_LOG selects groups of 4 columns (2) or 8 columns (3). The column mask is bits [2^BLK_LOG-1:0] of the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| casl_n | input | 1 | Lower byte column strobe, active low |
| casu_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| trg_n | input | 1 | Transfer gate; low at row-strobe fall selects refresh |
| dsf | input | 1 | Special-function select |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq | input | DATA_W | Data, mask and color bus |
| rd_row | input | ROW_BITS | Read port row |
| rd_col | input | COL_BITS | Read port column |
| rd_data | output | DATA_W | Registered read data, one clock after the address |
| cyc_type | output | 3 | Decoded cycle type of the open row cycle |

## Verification
A corrupted mask or color register does not show at once. It shows only in the word pattern left by the next block write, so each block write is followed by a full read of the affected row on both group sizes. A wrong decode appears on `cyc_type` within a few clocks of the row-strobe fall. A wrong capture edge, such as a later strobe overwriting the first value, leaves a complemented word at one column, and the readback after that same cycle exposes it. Decoys are driven on the bus at every later edge so that this error cannot hide.

// File: rtl/vbw_pkg.sv
package vbw_pkg;
  // Cycle kinds, decoded at the row-strobe fall
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_REFRESH = 3'd1,
    CYC_NORMAL  = 3'd2,
    CYC_LDMASK  = 3'd3,
    CYC_LDCOLOR = 3'd4,
    CYC_BLOCK   = 3'd5
  } cyc_e;
endpackage

// File: rtl/vbw_sync.sv
module vbw_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/vbw_ctrl.sv
module vbw_ctrl
  import vbw_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 5,
  parameter int USE_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_n_i,
  input  logic                cas_n_i,
  input  logic                we_n_i,
  input  logic                trg_n_i,
  input  logic                dsf_i,
  input  logic [USE_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]   dq_i,
  output cyc_e                cyc_o,
  output logic [DATA_W-1:0]   mask_o,
  output logic [DATA_W-1:0]   color_o,
  output logic                wr_norm_o,
  output logic                wr_blk_o,
  output logic [ROW_BITS-1:0] wr_row_o,
  output logic [COL_BITS-1:0] wr_col_o,
  output logic [DATA_W-1:0]   wr_data_o
);
  logic ras_p, cas_p, we_p;
  logic ras_fall, ras_rise, cas_fall, we_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
      we_p  <= 1'b1;
    end else begin
      ras_p <= ras_n_i;
      cas_p <= cas_n_i;
      we_p  <= we_n_i;
    end
  end

  assign ras_fall = ras_p & ~ras_n_i;
  assign ras_rise = ~ras_p & ras_n_i;
  assign cas_fall = cas_p & ~cas_n_i;
  assign we_fall  = we_p & ~we_n_i;

  cyc_e cyc_dec;
  always_comb begin
    if (!trg_n_i) cyc_dec = CYC_REFRESH;
    else begin
      case ({we_n_i, dsf_i})
        2'b00:   cyc_dec = CYC_LDMASK;
        2'b01:   cyc_dec = CYC_BLOCK;
        2'b10:   cyc_dec = CYC_NORMAL;
        default: cyc_dec = CYC_LDCOLOR;
      endcase
    end
  end

  cyc_e                cyc_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic [DATA_W-1:0]   dat_q, mask_q, color_q;
  logic                col_v_q, dat_v_q, we_seen_q;
  logic                wr_norm_q, wr_blk_q;
  logic                cyc_ok;

  assign cyc_ok = col_v_q & dat_v_q & we_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q     <= CYC_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      dat_q     <= '0;
      mask_q    <= '1;
      color_q   <= '0;
      col_v_q   <= 1'b0;
      dat_v_q   <= 1'b0;
      we_seen_q <= 1'b0;
      wr_norm_q <= 1'b0;
      wr_blk_q  <= 1'b0;
    end else begin
      wr_norm_q <= 1'b0;
      wr_blk_q  <= 1'b0;
      if (ras_fall) begin
        cyc_q     <= cyc_dec;
        row_q     <= addr_i[ROW_BITS-1:0];
        col_v_q   <= 1'b0;
        dat_v_q   <= 1'b0;
        we_seen_q <= ~we_n_i;
        if (cyc_dec == CYC_LDMASK) mask_q <= dq_i;
      end else if (ras_rise) begin
        cyc_q     <= CYC_IDLE;
        col_v_q   <= 1'b0;
        dat_v_q   <= 1'b0;
        we_seen_q <= 1'b0;
        case (cyc_q)
          CYC_NORMAL:  wr_norm_q <= cyc_ok;
          CYC_BLOCK:   wr_blk_q  <= cyc_ok;
          CYC_LDCOLOR: if (dat_v_q) color_q <= dat_q;
          default: ;
        endcase
      end else if (cyc_q != CYC_IDLE) begin
        if (!we_n_i) we_seen_q <= 1'b1;
        if (cas_fall && !col_v_q) begin
          col_q   <= addr_i[COL_BITS-1:0];
          col_v_q <= 1'b1;
        end
        if ((cas_fall || we_fall) && !dat_v_q) begin
          dat_q   <= dq_i;
          dat_v_q <= 1'b1;
        end
      end
    end
  end

  assign cyc_o     = cyc_q;
  assign mask_o    = mask_q;
  assign color_o   = color_q;
  assign wr_norm_o = wr_norm_q;
  assign wr_blk_o  = wr_blk_q;
  assign wr_row_o  = row_q;
  assign wr_col_o  = col_q;
  assign wr_data_o = dat_q;

  // R2
  cyc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q != CYC_IDLE && !ras_rise) |=> (cyc_q == $past(cyc_q)));
  // R2
  cyc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ras_p && ras_n_i) |-> (cyc_q == CYC_IDLE));
  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(ras_fall && cyc_dec == CYC_LDMASK) |=> $stable(mask_q));
  // R4
  color_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(ras_rise && cyc_q == CYC_LDCOLOR && dat_v_q) |=> $stable(color_q));
  // R4
  data_first_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_v_q && !ras_rise && !ras_fall) |=> $stable(dat_q));
endmodule

// File: rtl/vbw_array.sv
module vbw_array #(
  parameter int DATA_W   = 16,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 5,
  parameter int BLK_LOG  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_norm_i,
  input  logic                wr_blk_i,
  input  logic [ROW_BITS-1:0] wr_row_i,
  input  logic [COL_BITS-1:0] wr_col_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [DATA_W-1:0]   mask_i,
  input  logic [DATA_W-1:0]   color_i,
  input  logic [ROW_BITS-1:0] rd_row_i,
  input  logic [COL_BITS-1:0] rd_col_i,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;
  localparam int BLK  = 1 << BLK_LOG;

  logic [DATA_W-1:0]   mem_q [ROWS][COLS];
  logic [DATA_W-1:0]   rd_q;
  logic [COL_BITS-1:0] bcol  [BLK];

  // Column index of each member of the addressed group
  for (genvar k = 0; k < BLK; k++) begin : g_bcol
    assign bcol[k] = {wr_col_i[COL_BITS-1:BLK_LOG], BLK_LOG'(k)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem_q[r][c] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_norm_i) mem_q[wr_row_i][wr_col_i] <= wr_data_i;
      for (int k = 0; k < BLK; k++)
        if (wr_blk_i && wr_data_i[k])
          mem_q[wr_row_i][bcol[k]] <= (mem_q[wr_row_i][bcol[k]] & ~mask_i)
                                    | (color_i & mask_i);
      rd_q <= mem_q[rd_row_i][rd_col_i];
    end
  end

  assign rd_data_o = rd_q;

  // R7
  wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_norm_i && wr_blk_i));
  // R8
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_norm_i || wr_blk_i) |=> !(wr_norm_i || wr_blk_i));
endmodule

// File: rtl/vram_blkwr_engine.sv
module vram_blkwr_engine
  import vbw_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 16,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 5,
  parameter int BLK_LOG  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_n,
  input  logic                casl_n,
  input  logic                casu_n,
  input  logic                we_n,
  input  logic                trg_n,
  input  logic                dsf,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dq,
  input  logic [ROW_BITS-1:0] rd_row,
  input  logic [COL_BITS-1:0] rd_col,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2:0]          cyc_type
);
  localparam int USE_W = (COL_BITS > ROW_BITS) ? COL_BITS : ROW_BITS;
  localparam int BUS_W = USE_W + DATA_W;

  logic unused_addr_hi;
  assign unused_addr_hi = ^addr[ADDR_W-1:USE_W];

  logic [5:0]       stb_s;
  logic [BUS_W-1:0] bus_s;

  vbw_sync #(.WIDTH(6), .RST_VAL(6'b111110)) stb_sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({ras_n, casl_n, casu_n, we_n, trg_n, dsf}),
    .q_o (stb_s)
  );

  vbw_sync #(.WIDTH(BUS_W), .RST_VAL('0)) bus_sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({addr[USE_W-1:0], dq}),
    .q_o (bus_s)
  );

  logic cas_n_s;
  assign cas_n_s = stb_s[4] & stb_s[3];

  cyc_e                cyc_w;
  logic [DATA_W-1:0]   mask_w, color_w, wr_data_w;
  logic                wr_norm_w, wr_blk_w;
  logic [ROW_BITS-1:0] wr_row_w;
  logic [COL_BITS-1:0] wr_col_w;

  vbw_ctrl #(
    .DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .USE_W(USE_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .ras_n_i   (stb_s[5]),
    .cas_n_i   (cas_n_s),
    .we_n_i    (stb_s[2]),
    .trg_n_i   (stb_s[1]),
    .dsf_i     (stb_s[0]),
    .addr_i    (bus_s[BUS_W-1:DATA_W]),
    .dq_i      (bus_s[DATA_W-1:0]),
    .cyc_o     (cyc_w),
    .mask_o    (mask_w),
    .color_o   (color_w),
    .wr_norm_o (wr_norm_w),
    .wr_blk_o  (wr_blk_w),
    .wr_row_o  (wr_row_w),
    .wr_col_o  (wr_col_w),
    .wr_data_o (wr_data_w)
  );

  vbw_array #(
    .DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .BLK_LOG(BLK_LOG)
  ) array_i (
    .clk       (clk),
    .rst       (rst),
    .wr_norm_i (wr_norm_w),
    .wr_blk_i  (wr_blk_w),
    .wr_row_i  (wr_row_w),
    .wr_col_i  (wr_col_w),
    .wr_data_i (wr_data_w),
    .mask_i    (mask_w),
    .color_i   (color_w),
    .rd_row_i  (rd_row),
    .rd_col_i  (rd_col),
    .rd_data_o (rd_data)
  );

  assign cyc_type = cyc_w;
endmodule

// File: tb/vram_blkwr_engine_tb.sv
module vram_blkwr_engine_tb_top;
  localparam int HALF = 2500;  // 200 MHz with a 1 ps time unit
  localparam longint WD_LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        ras_n, casl_n, casu_n, we_n, trg_n, dsf;
  logic [8:0]  addr;
  logic [15:0] dq;
  logic [1:0]  rd_row;
  logic [4:0]  rd_col;
  logic [15:0] rd4, rd8;
  logic [2:0]  cyc4, cyc8;

  int checks = 0;
  int errors = 0;

  logic [15:0] m4 [4][32];
  logic [15:0] m8 [4][32];
  logic [15:0] mask_r, color_r;

  always #HALF clk = ~clk;

  vram_blkwr_engine #(.BLK_LOG(2)) dut_i (
    .clk(clk), .rst(rst), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
    .we_n(we_n), .trg_n(trg_n), .dsf(dsf), .addr(addr), .dq(dq),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd4), .cyc_type(cyc4));

  vram_blkwr_engine #(.BLK_LOG(3)) dut8_i (
    .clk(clk), .rst(rst), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
    .we_n(we_n), .trg_n(trg_n), .dsf(dsf), .addr(addr), .dq(dq),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd8), .cyc_type(cyc8));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #100;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_cyc(input logic [2:0] exp, input string req);
    chk(cyc4 == exp, req, {29'd0, cyc4}, {29'd0, exp});
    chk(cyc8 == exp, req, {29'd0, cyc8}, {29'd0, exp});
  endtask

  task automatic row_open(input logic [8:0] a, input logic t, input logic w,
                          input logic d, input logic [15:0] data);
    addr = a; trg_n = t; we_n = w; dsf = d; dq = data;
    cyc(1);
    ras_n = 1'b0;
    cyc(5);
  endtask

  task automatic col_fall(input logic [8:0] a, input logic [15:0] data,
                          input bit lo, input bit hi);
    addr = a; dq = data;
    cyc(1);
    if (lo) casl_n = 1'b0;
    if (hi) casu_n = 1'b0;
    cyc(5);
  endtask

  task automatic we_fall(input logic [15:0] data);
    dq = data;
    cyc(1);
    we_n = 1'b0;
    cyc(5);
  endtask

  task automatic row_close;
    ras_n = 1'b1;
    cyc(6);
    casl_n = 1'b1; casu_n = 1'b1; we_n = 1'b1; trg_n = 1'b1; dsf = 1'b0;
    cyc(5);
  endtask

  task automatic cmp_row(input logic [1:0] r, input string req);
    for (int c = 0; c < 32; c++) begin
      rd_row = r; rd_col = 5'(c);
      cyc(3);
      chk(rd4 == m4[r][c], req, {16'd0, rd4}, {16'd0, m4[r][c]});
      chk(rd8 == m8[r][c], req, {16'd0, rd8}, {16'd0, m8[r][c]});
    end
  endtask

  task automatic ref_block(input logic [1:0] r, input logic [4:0] col,
                           input logic [15:0] cm);
    for (int k = 0; k < 8; k++) begin
      if (k < 4 && cm[k]) begin
        int c4 = (int'(col) / 4) * 4 + k;
        m4[r][c4] = (m4[r][c4] & ~mask_r) | (color_r & mask_r);
      end
      if (cm[k]) begin
        int c8 = (int'(col) / 8) * 8 + k;
        m8[r][c8] = (m8[r][c8] & ~mask_r) | (color_r & mask_r);
      end
    end
  endtask

  // R3: mask sampled at row-strobe fall
  task automatic op_load_mask(input logic [15:0] m);
    row_open(9'h000, 1'b1, 1'b0, 1'b0, m);
    chk_cyc(3'd3, "R2 load-mask decode");
    dq = ~m;
    row_close();
    chk_cyc(3'd0, "R2 idle after rise");
    mask_r = m;
  endtask

  // R4: color from first of write-enable fall / column fall
  task automatic op_load_color(input logic [15:0] c, input bit we_first);
    row_open(9'h000, 1'b1, 1'b1, 1'b1, 16'h0);
    chk_cyc(3'd4, "R2 load-color decode");
    if (we_first) begin
      we_fall(c);
      col_fall(9'h003, ~c, 1'b1, 1'b1);
    end else begin
      col_fall(9'h003, c, 1'b1, 1'b1);
      we_fall(~c);
    end
    row_close();
    color_r = c;
  endtask

  // R7 / R6 / R10: block write then full row readback
  task automatic op_block(input logic [8:0] r_a, input logic [8:0] c_a,
                          input logic [15:0] cm, input bit lo, input bit hi,
                          input string req);
    row_open(r_a, 1'b1, 1'b0, 1'b1, 16'h0);
    chk_cyc(3'd5, "R2 block decode");
    col_fall(c_a, cm, lo, hi);
    dq = ~cm;
    row_close();
    ref_block(r_a[1:0], c_a[4:0], cm);
    cmp_row(r_a[1:0], req);
  endtask

  // R8: mode 0 WE first, 1 column first, 2 no WE at all
  task automatic op_normal(input logic [8:0] r_a, input logic [8:0] c_a,
                           input logic [15:0] data, input int mode,
                           input string req);
    row_open(r_a, 1'b1, 1'b1, 1'b0, 16'h0);
    chk_cyc(3'd2, "R2 normal decode");
    if (mode == 0) begin
      we_fall(data);
      col_fall(c_a, ~data, 1'b1, 1'b1);
    end else if (mode == 1) begin
      col_fall(c_a, data, 1'b1, 1'b1);
      we_fall(~data);
    end else begin
      col_fall(c_a, data, 1'b1, 1'b1);
    end
    row_close();
    if (mode != 2) begin
      m4[r_a[1:0]][c_a[4:0]] = data;
      m8[r_a[1:0]][c_a[4:0]] = data;
    end
    cmp_row(r_a[1:0], req);
  endtask

  task automatic t_reset;
    chk_cyc(3'd0, "R1 idle at reset");
    for (int r = 0; r < 4; r++) cmp_row(2'(r), "R1 array cleared");
  endtask

  task automatic t_default_mask;
    op_load_color(16'hA5C3, 1'b1);
    op_block(9'h001, 9'h005, 16'h00FF, 1'b1, 1'b1, "R1 reset mask all ones");
  endtask

  task automatic t_persistent_mask;
    op_load_mask(16'h0FF0);
    op_load_color(16'h1234, 1'b0);
    op_block(9'h002, 9'h010, 16'h0005, 1'b1, 1'b1, "R7 column and bit mask");
    op_load_color(16'hFEDC, 1'b1);
    op_block(9'h002, 9'h011, 16'h00FF, 1'b1, 1'b1, "R3 mask persists");
  endtask

  task automatic t_block_addr;
    op_load_mask(16'hFFFF);
    op_load_color(16'h5A5A, 1'b0);
    op_block(9'h1ED, 9'h1ED, 16'h00A6, 1'b1, 1'b1, "R6 group alignment");
    op_block(9'h003, 9'h01F, 16'h0081, 1'b0, 1'b1, "R5 upper strobe only");
  endtask

  task automatic t_normal;
    op_normal(9'h000, 9'h007, 16'hBEEF, 0, "R4 WE edge first");
    op_normal(9'h000, 9'h008, 16'hCAFE, 1, "R4 column edge first");
    op_normal(9'h000, 9'h009, 16'h7777, 2, "R8 no WE no write");
  endtask

  task automatic t_split_strobe;
    row_open(9'h001, 1'b1, 1'b1, 1'b0, 16'h0);
    col_fall(9'h00C, 16'h1357, 1'b1, 1'b0);
    col_fall(9'h00D, 16'h2468, 1'b0, 1'b1);
    we_fall(16'h9999);
    row_close();
    m4[1][12] = 16'h1357;
    m8[1][12] = 16'h1357;
    cmp_row(2'd1, "R5 second byte strobe ignored");
  endtask

  task automatic t_refresh;
    row_open(9'h002, 1'b0, 1'b1, 1'b0, 16'h0);
    chk_cyc(3'd1, "R9 refresh decode");
    col_fall(9'h011, 16'hFFFF, 1'b1, 1'b1);
    we_fall(16'h0000);
    row_close();
    cmp_row(2'd2, "R9 refresh no change");
  endtask

  task automatic t_random;
    for (int i = 0; i < 12; i++) begin
      logic [15:0] v;
      if (i % 3 == 0) begin
        v = 16'($urandom);
        op_load_mask(v);
      end
      v = 16'($urandom);
      op_load_color(v, (i % 2) == 0);
      op_block(9'($urandom), 9'($urandom), 16'($urandom), 1'b1, (i % 4) != 1,
               "R7 R10 random block");
    end
  endtask

  initial begin
    #(WD_LIMIT * 2 * HALF);
    errors++;
    $display("FAIL watchdog R2 cycle flow: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst = 1'b1;
    ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1; we_n = 1'b1; trg_n = 1'b1;
    dsf = 1'b0; addr = '0; dq = '0; rd_row = '0; rd_col = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 32; c++) begin
        m4[r][c] = '0;
        m8[r][c] = '0;
      end
    mask_r = 16'hFFFF;
    color_r = 16'h0000;
    cyc(5);
    rst = 1'b0;
    cyc(4);
    t_reset();
    t_default_mask();
    t_persistent_mask();
    t_block_addr();
    t_normal();
    t_split_strobe();
    t_refresh();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule